// File: doc/BRIEF.md
# Three-Wire Register Access Port

This block is a serial slave that gives an external host write and read access to a small internal bank of byte-wide configuration registers. The host pulls an active-low select line low and toggles a serial clock. It first shifts in an instruction byte that holds a read/write flag and a starting register address. It then moves any number of data bytes, and the register address steps by one after every completed byte. Read data returns either on the shared data line or on a separate output line. The line is chosen by a bit of register 0, and its enable tells the pad logic when to drive.

The serial pins are brought into the system clock domain through synchronizers and handled there as edge events. The system clock must therefore be fast enough that each high or low phase of the serial clock lasts at least four system clock cycles. Register 0 also holds the bit-order control. Writes to register 0 are stored at once but steer the port only from the next transaction onward. Registers 1 and up sit in an inferable RAM and have no reset value.

Top module: `twire_reg_port`

## Requirements
- R1: After reset both output enables are low, and register 0 reads back 0x00 (MSB-first order, read data on the separate output line).
- R2: The first eight rising serial clock edges after select goes low carry the instruction byte. Bit 7 = 1 requests a read and 0 a write. Bits 4:0 give the starting address. Bits 6:5 are ignored.
- R3: Write data is sampled on rising edges and stored once its eighth bit arrives. A later read of the same address returns it.
- R4: In MSB-first order (register 0 bit 6 = 0), instruction and data bits arrive most significant first, and the address decrements after each byte, wrapping from 0 to 31.
- R5: In LSB-first order (register 0 bit 6 = 1), bits arrive least significant first, and the address increments after each byte, wrapping from 31 to 0.
- R6: Read data changes only after falling serial clock edges. The first bit of a read appears after the falling edge that follows the eighth rising edge, and each bit holds steady through the next rising edge.
- R7: With register 0 bit 7 = 1, read data leaves on sdio_out with sdio_oe high. With bit 7 = 0, it leaves on sdo_out with sdo_oe high. The two enables are never high together.
- R8: A write to register 0 changes bit order and output line selection only after select has returned high. Later bytes of the same transaction keep the old settings.
- R9: Both enables stay low during the instruction byte and write bytes, and they are low within four clock cycles after select is seen high.
- R10: If select rises before a data byte is complete, the partial byte is discarded and the target register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_in | input | 1 | Receive side of the shared data line |
| sdio_out | output | 1 | Read data toward the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_out | output | 1 | Read data on the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |

## Verification
The properties assume that the host changes sclk, cs_n and sdio_in slowly compared with clk. Each serial clock phase is taken to last long enough that a synchronized edge, the registered RAM read and the registered output all settle before the opposite edge. The stimulus holds every serial clock phase for eight system cycles. It changes the data line only while the serial clock is low, and it keeps select steady for several cycles around each transaction. The random transactions draw start addresses, lengths, directions and register-0 values freely. This includes writes to register 0 that land mid-transaction, so the delayed-configuration and wrap-around behaviour is reached from many states.

// File: rtl/twp_pkg.sv
package twp_pkg;

  typedef enum logic {PH_INSTR, PH_DATA} phase_e;

  typedef struct packed {
    logic bidir;      // read data on the shared line
    logic lsb_first;  // serial bit order
  } port_cfg_t;

  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned CFG_BIDIR_POS = 7;
  localparam int unsigned CFG_LSB_POS   = 6;
  localparam int unsigned RD_FLAG_POS   = 7;

  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= RST_VAL;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twp_regfile.sv
module twp_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/twp_engine.sv
module twp_engine
  import twp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              tx_active,
  output logic              fall_evt,
  output logic              step_evt
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_e            phase;
  logic              sclk_d;
  logic              rd_mode;
  logic [CNT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic [BYTE_W-1:0] rx_next;
  logic [BYTE_W-1:0] tx_load;
  logic [ADDR_W-1:0] addr_stepped;
  logic              rise_evt;
  logic              byte_end;

  assign rise_evt     = sclk_s & ~sclk_d & ~cs_s;
  assign fall_evt     = ~sclk_s & sclk_d & ~cs_s;
  assign byte_end     = rise_evt & (bit_idx == LAST_BIT);
  assign step_evt     = byte_end & (phase == PH_DATA);
  assign rx_next      = lsb_first ? {din_s, rx_sr[BYTE_W-1:1]} : {rx_sr[BYTE_W-2:0], din_s};
  assign tx_load      = lsb_first ? flip_byte(rd_byte) : rd_byte;
  assign addr_stepped = lsb_first ? cur_addr + 1'b1 : cur_addr - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_INSTR;
      rd_mode   <= 1'b0;
      bit_idx   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      tx_bit    <= 1'b0;
      tx_active <= 1'b0;
      cur_addr  <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_s) begin
        phase     <= PH_INSTR;
        bit_idx   <= '0;
        tx_active <= 1'b0;
      end else begin
        if (rise_evt) begin
          rx_sr   <= rx_next;
          bit_idx <= bit_idx + 1'b1;
        end
        if (byte_end && phase == PH_INSTR) begin
          phase    <= PH_DATA;
          rd_mode  <= rx_next[RD_FLAG_POS];
          cur_addr <= rx_next[ADDR_W-1:0];
        end
        if (step_evt) begin
          cur_addr <= addr_stepped;
          if (!rd_mode) begin
            wr_en   <= 1'b1;
            wr_addr <= cur_addr;
            wr_data <= rx_next;
          end
        end
        if (fall_evt && phase == PH_DATA && rd_mode) begin
          if (bit_idx == '0) begin
            tx_bit    <= tx_load[BYTE_W-1];
            tx_sr     <= {tx_load[BYTE_W-2:0], 1'b0};
            tx_active <= 1'b1;
          end else begin
            tx_bit <= tx_sr[BYTE_W-1];
            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/twire_reg_port.sv
module twire_reg_port
  import twp_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo_out,
  output logic sdo_oe
);
  logic [2:0]        pins_s;
  logic              cs_s;
  logic              sclk_s;
  logic              din_s;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] mem_q;
  logic [BYTE_W-1:0] ctrl_reg;
  logic [BYTE_W-1:0] rd_byte;
  logic              sel_ctrl_q;
  logic              tx_bit;
  logic              tx_active;
  logic              fall_evt;
  logic              step_evt;
  port_cfg_t         cfg_act;
  logic              cfg_lsb;
  logic              cfg_bidir;

  twp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdio_in}), .q(pins_s)
  );
  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  assign cfg_lsb   = cfg_act.lsb_first;
  assign cfg_bidir = cfg_act.bidir;

  twp_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .din_s(din_s),
    .lsb_first(cfg_lsb), .rd_byte(rd_byte), .cur_addr(cur_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_bit(tx_bit), .tx_active(tx_active),
    .fall_evt(fall_evt), .step_evt(step_evt)
  );

  twp_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_regs (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(mem_q)
  );

  // register 0 lives in flops so it has a reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_reg   <= '0;
      sel_ctrl_q <= 1'b0;
      cfg_act    <= '0;
    end else begin
      if (wr_en && wr_addr == '0) ctrl_reg <= wr_data;
      sel_ctrl_q <= (cur_addr == '0);
      if (cs_s) begin
        cfg_act.bidir     <= ctrl_reg[CFG_BIDIR_POS];
        cfg_act.lsb_first <= ctrl_reg[CFG_LSB_POS];
      end
    end
  end

  assign rd_byte = sel_ctrl_q ? ctrl_reg : mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdio_out <= 1'b0;
      sdo_out  <= 1'b0;
      sdio_oe  <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      sdio_out <= tx_bit;
      sdo_out  <= tx_bit;
      sdio_oe  <= tx_active & ~cs_s & cfg_bidir;
      sdo_oe   <= tx_active & ~cs_s & ~cfg_bidir;
    end
  end
endmodule

// File: rtl/twp_checker.sv
module twp_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              cs_s,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic              sdo_out,
  input logic              fall_evt,
  input logic              step_evt,
  input logic              cfg_lsb,
  input logic              cfg_bidir,
  input logic [ADDR_W-1:0] cur_addr
);
  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 3'd7)  age <= age + 3'd1;
  end

  // R7
  oe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(sdio_oe && sdo_oe));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(cs_n, 4)) |-> (!sdio_oe && !sdo_oe));

  // R6
  fall_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && sdo_out != $past(sdo_out)) |-> $past(fall_evt, 2));

  // R4 R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> (cur_addr == ($past(cfg_lsb) ? ADDR_W'($past(cur_addr) + 1'b1)
                                              : ADDR_W'($past(cur_addr) - 1'b1))));

  // R8
  cfg_idle_only_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && (cfg_lsb != $past(cfg_lsb) || cfg_bidir != $past(cfg_bidir)))
      |-> $past(cs_s));
endmodule

bind twire_reg_port twp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cs_s(cs_s),
  .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .sdo_out(sdo_out),
  .fall_evt(fall_evt), .step_evt(step_evt),
  .cfg_lsb(cfg_lsb), .cfg_bidir(cfg_bidir), .cur_addr(cur_addr)
);

// File: tb/test_twire_reg_port.sv
module test_twire_reg_port;
  localparam int NREG = 32;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cs_n, sclk, sdio_in;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;

  twire_reg_port i_twire_reg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  bit   m_lsb, m_bidir;
  logic [7:0] exp_mem [NREG];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int next_addr(input int a, input bit lsb);
    return lsb ? (a + 1) % NREG : (a + NREG - 1) % NREG;
  endfunction

  // one serial bit: low phase, sample, rising edge, high phase
  task automatic bit_cycle(input logic b, input bit is_rd, output logic got);
    logic again;
    sdio_in = b;
    wait_clk(HALF);
    got = m_bidir ? sdio_out : sdo_out;
    if (is_rd) check("R7", {m_bidir ? sdio_oe : sdo_oe, m_bidir ? sdo_oe : sdio_oe}, 2'b10);
    else       check("R9", {sdio_oe, sdo_oe}, 2'b00);
    sclk = 1'b1;
    wait_clk(HALF);
    again = m_bidir ? sdio_out : sdo_out;
    if (is_rd) check("R6", again, got);
    sclk = 1'b0;
  endtask

  task automatic send_instr(input bit rd, input int start, input bit lsb);
    logic [7:0] instr;
    logic got;
    instr = {rd, 2'($urandom), 5'(start)};   // R2: bits 6:5 random
    for (int i = 0; i < 8; i++) bit_cycle(lsb ? instr[i] : instr[7-i], 1'b0, got);
  endtask

  task automatic xfer(input bit rd, input int start, input int n, input string tag);
    bit   lsb0;
    int   a;
    logic got;
    int   idx;
    lsb0 = m_lsb;
    cs_n = 1'b0;
    wait_clk(4);
    send_instr(rd, start, lsb0);
    a = start;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        idx = lsb0 ? i : 7 - i;
        bit_cycle(rd ? 1'b0 : wbuf[k][idx], rd, got);
        rbuf[k][idx] = got;
      end
      if (rd) check(tag, rbuf[k], exp_mem[a]);
      else    exp_mem[a] = wbuf[k];
      a = next_addr(a, lsb0);
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
    check("R9", {sdio_oe, sdo_oe}, 2'b00);
    m_lsb   = exp_mem[0][6];
    m_bidir = exp_mem[0][7];
  endtask

  task automatic abort_write(input int target, input int nbits);
    logic got;
    cs_n = 1'b0;
    wait_clk(4);
    send_instr(1'b0, target, m_lsb);
    for (int i = 0; i < nbits; i++) bit_cycle(1'b1, 1'b0, got);
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdio_in = 1'b0;
    m_lsb = 1'b0; m_bidir = 1'b0;
    for (int i = 0; i < NREG; i++) exp_mem[i] = 8'h00;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(6);
    check("R1", {sdio_oe, sdo_oe}, 2'b00);
    xfer(1'b1, 0, 1, "R1");

    // fill every register, MSB-first, addresses 31 down to 0
    for (int k = 0; k < NREG; k++) wbuf[k] = 8'($urandom);
    wbuf[31] = 8'h00;
    xfer(1'b0, 31, 32, "R3");
    xfer(1'b1, 31, 32, "R4");
    xfer(1'b1, 4, 2, "R2");

    // write 1, 0, 31 (wrap); register 0 switches to LSB-first mid-transaction
    wbuf[0] = 8'hA5; wbuf[1] = 8'h40; wbuf[2] = 8'h3C;
    xfer(1'b0, 1, 3, "R8");
    xfer(1'b1, 31, 3, "R5");       // LSB-first read 31, 0, 1
    xfer(1'b1, 2, 2, "R8");

    // LSB-first write 30, 31, 0, 1 enabling shared-line reads
    wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'hC0; wbuf[3] = 8'h19;
    xfer(1'b0, 30, 4, "R5");
    xfer(1'b1, 30, 4, "R7");

    // back to MSB-first, shared line
    wbuf[0] = 8'h80;
    xfer(1'b0, 0, 1, "R8");
    xfer(1'b1, 2, 3, "R8");

    // abandoned partial byte
    wbuf[0] = 8'h5A;
    xfer(1'b0, 5, 1, "R10");
    abort_write(5, 4);
    xfer(1'b1, 5, 1, "R10");
    abort_write(7, 7);
    xfer(1'b1, 7, 1, "R10");

    // constrained random transactions
    for (int t = 0; t < 60; t++) begin
      bit rd;
      int start, n;
      rd    = 1'($urandom);
      start = int'($urandom % NREG);
      n     = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      xfer(rd, start, n, rd ? "R3" : "R4");
    end
    xfer(1'b1, 0, 32, "R3");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule